// File: doc/BRIEF.md
# Transmit Start and Post-Transmit Timing Controller

This block sequences a single transmission of a wireless transmit pipeline. It decides when the pipeline starts. A software start pulse always starts it at once. Otherwise a configuration bit picks the hardware source: a dedicated direct-start input, or a MAC start request followed by a programmed delay. Once the pipeline reports that its last sample has gone to the converters, three independent hold timers run. One ends in a single-cycle end-of-transmit pulse to the MAC. The other two release the receive-signals-invalid flag and the user transmit-enable level.

Every delay counts ticks of four clock cycles. A shared prescaler makes the ticks, and it is re-aligned at each start request and at the last-sample event, so each delay lands on an exact cycle. A delay of zero makes its event happen in the cycle after the trigger. The block drives a running flag for the whole transmission, including the post-transmit extension. It also drives an optional receive-enable that is high only while the transmitter is idle. A pipeline-reset input clears all sequencing state. The configuration ports are not touched by it.

Top module: `tx_seq_ctrl`

## Requirements
- R1: With `cfg_start_sel`=0, a high `direct_start_i` sampled while idle makes `pipe_start` a one-cycle pulse in the next cycle. `mac_start_req` is ignored in this setting.
- R2: With `cfg_start_sel`=1, a high `mac_start_req` sampled while idle makes `pipe_start` pulse exactly 4*`cfg_start_dly` cycles later than a direct start would. `direct_start_i` is ignored in this setting.
- R3: Any programmed delay of 0 (start or post-transmit) makes its event appear in the cycle right after its trigger.
- R4: A high `sw_start` sampled while idle starts a transmission at once, whatever the value of `cfg_start_sel`.
- R5: `tx_end_ind` is a one-cycle pulse. It appears 4*`cfg_end_dly` cycles after the cycle that follows the sampled `last_sample`.
- R6: `rx_sigs_invalid` rises together with `pipe_start`. It falls 4*`cfg_inval_dly` cycles after the cycle that follows `last_sample`.
- R7: `usr_txen` rises together with `pipe_start`. It falls 4*`cfg_txen_dly` cycles after the cycle that follows `last_sample`.
- R8: `tx_running` rises in the cycle after a start is accepted. It falls when the longest of the three post-transmit delays expires.
- R9: `rx_en` equals `cfg_rxen_opt` AND NOT `tx_running`.
- R10: Start requests of any kind are ignored while `tx_running` is high, and so is a `last_sample` that arrives outside the active phase.
- R11: A high `cfg_pipe_rst` clears all sequencing state, so that `tx_running`, `rx_sigs_invalid`, `usr_txen`, `pipe_start` and `tx_end_ind` are low in the next cycle. A later start behaves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_start_sel | input | 1 | 0: direct start input; 1: delayed MAC request |
| cfg_start_dly | input | 14 | Start delay in 4-cycle ticks |
| cfg_end_dly | input | 10 | End-indication delay in 4-cycle ticks |
| cfg_inval_dly | input | 10 | Receive-invalid hold in 4-cycle ticks |
| cfg_txen_dly | input | 10 | Transmit-enable hold in 4-cycle ticks |
| cfg_rxen_opt | input | 1 | Enables receive-enable while idle |
| cfg_pipe_rst | input | 1 | Clears sequencing state |
| sw_start | input | 1 | Software start pulse |
| direct_start_i | input | 1 | Dedicated hardware start |
| mac_start_req | input | 1 | MAC start request |
| last_sample | input | 1 | Pipeline's last sample sent |
| pipe_start | output | 1 | Start pulse to the pipeline |
| tx_end_ind | output | 1 | End-of-transmit pulse to MAC |
| rx_sigs_invalid | output | 1 | Receive signals invalid level |
| usr_txen | output | 1 | User transmit-enable level |
| tx_running | output | 1 | Transmission in progress |
| rx_en | output | 1 | Receive enable while idle |

## Verification
A misaligned prescaler or a wrong tick count moves `pipe_start`, `tx_end_ind` or a level edge by one to three cycles, and that error is visible as soon as the event is due. A stuck phase keeps `tx_running` high and `rx_en` low past the longest delay, or lets a request that should be ignored restart the sequence, which shows up as an extra `pipe_start` within one cycle. Every output is compared in every cycle of each transmission, under random delays and sources, so the first wrong cycle is reported.

// File: rtl/tx_seq_pkg.sv
// Shared types for the transmit sequencer.
package tx_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WAIT   = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_POST   = 2'd3
    } seq_phase_e;
endpackage

// File: rtl/tick_prescaler.sv
// Divide-by-DIV tick generator shared by every delay timer.
// Assumes: DIV >= 2. A realign request restarts the count so that the
// first tick comes DIV cycles after the realign edge.
module tick_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic realign,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    assign tick = (cnt == CW'(DIV - 1));

    // Free-running phase counter, restarted on realign or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || realign) cnt <= '0;
        else if (tick)                cnt <= '0;
        else                          cnt <= cnt + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/hold_timer.sv
// One-shot tick counter: fires when DLY ticks have passed since arm.
// Assumes: dly is held stable while the timer is busy. A zero delay fires
// in the arm cycle itself (combinational fire output).
module hold_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         arm,
    input  logic         tick,
    input  logic [W-1:0] dly,
    output logic         fire
);
    logic         busy;
    logic [W-1:0] cnt;
    logic [W:0]   next_cnt;
    logic         reached;

    assign next_cnt = {1'b0, cnt} + 1'b1;
    assign reached  = (next_cnt >= {1'b0, dly});
    assign fire     = arm ? (dly == '0) : (busy && tick && reached);

    // Tick count, armed by the owner and stopped on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (arm) begin
            busy <= (dly != '0);
            cnt  <= '0;
        end else if (busy && tick) begin
            if (reached) busy <= 1'b0;
            else         cnt  <= next_cnt[W-1:0];
        end
    end

    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (fire && !arm) |=> !busy); // R8
endmodule

// File: rtl/tx_seq_ctrl.sv
// Transmit start and post-transmit timing controller.
// Picks the start source, applies the programmed start delay, and after the
// last output sample runs three hold timers (end pulse, receive-invalid,
// transmit-enable). Assumes: configuration stays stable during a transmission;
// last_sample is a single-cycle pulse from the pipeline.
module tx_seq_ctrl
    import tx_seq_pkg::*;
#(
    parameter int START_W  = 14,
    parameter int POST_W   = 10,
    parameter int TICK_DIV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_start_sel,
    input  logic [START_W-1:0] cfg_start_dly,
    input  logic [POST_W-1:0]  cfg_end_dly,
    input  logic [POST_W-1:0]  cfg_inval_dly,
    input  logic [POST_W-1:0]  cfg_txen_dly,
    input  logic               cfg_rxen_opt,
    input  logic               cfg_pipe_rst,
    input  logic               sw_start,
    input  logic               direct_start_i,
    input  logic               mac_start_req,
    input  logic               last_sample,
    output logic               pipe_start,
    output logic               tx_end_ind,
    output logic               rx_sigs_invalid,
    output logic               usr_txen,
    output logic               tx_running,
    output logic               rx_en
);
    localparam int NPOST   = 3;
    localparam int IDX_END = 0;
    localparam int IDX_INV = 1;
    localparam int IDX_TXE = 2;

    seq_phase_e                    phase;
    logic                          tick;
    logic                          idle;
    logic                          imm_start;
    logic                          start_arm;
    logic                          start_fire;
    logic                          go;
    logic                          post_arm;
    logic                          all_done;
    logic [NPOST-1:0]              post_fire;
    logic [NPOST-1:0]              post_done;
    logic [NPOST-1:0][POST_W-1:0]  post_dly;
    logic                          pipe_start_q;
    logic                          end_q;
    logic                          inval_q;
    logic                          txen_q;

    assign idle      = (phase == PH_IDLE);
    assign imm_start = idle && (sw_start || (!cfg_start_sel && direct_start_i));
    assign start_arm = idle && !imm_start && cfg_start_sel && mac_start_req;
    assign go        = imm_start || start_fire;
    assign post_arm  = (phase == PH_ACTIVE) && last_sample;
    assign all_done  = &(post_done | post_fire);

    assign post_dly[IDX_END] = cfg_end_dly;
    assign post_dly[IDX_INV] = cfg_inval_dly;
    assign post_dly[IDX_TXE] = cfg_txen_dly;

    tick_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cfg_pipe_rst),
        .realign (start_arm || post_arm),
        .tick    (tick)
    );

    hold_timer #(.W(START_W)) u_start_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_pipe_rst),
        .arm   (start_arm),
        .tick  (tick),
        .dly   (cfg_start_dly),
        .fire  (start_fire)
    );

    for (genvar i = 0; i < NPOST; i++) begin : g_post
        hold_timer #(.W(POST_W)) u_post_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cfg_pipe_rst),
            .arm   (post_arm),
            .tick  (tick),
            .dly   (post_dly[i]),
            .fire  (post_fire[i])
        );
    end

    // Sequencing phase: idle, start delay, active, post-transmit extension.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_pipe_rst) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE:   if (go)             phase <= PH_ACTIVE;
                           else if (start_arm) phase <= PH_WAIT;
                PH_WAIT:   if (start_fire)     phase <= PH_ACTIVE;
                PH_ACTIVE: if (last_sample)    phase <= all_done ? PH_IDLE : PH_POST;
                PH_POST:   if (all_done)       phase <= PH_IDLE;
                default:                       phase <= PH_IDLE;
            endcase
        end
    end

    // Record which post-transmit timers have already expired.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_pipe_rst)  post_done <= '0;
        else if (post_arm)           post_done <= post_fire;
        else if (phase == PH_POST)   post_done <= post_done | post_fire;
        else                         post_done <= '0;
    end

    // Registered start and end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_pipe_rst) begin
            pipe_start_q <= 1'b0;
            end_q        <= 1'b0;
        end else begin
            pipe_start_q <= go;
            end_q        <= post_fire[IDX_END];
        end
    end

    // Hold levels: set at pipeline start, released by their own timers.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_pipe_rst) begin
            inval_q <= 1'b0;
            txen_q  <= 1'b0;
        end else begin
            if (go)                      inval_q <= 1'b1;
            else if (post_fire[IDX_INV]) inval_q <= 1'b0;
            if (go)                      txen_q  <= 1'b1;
            else if (post_fire[IDX_TXE]) txen_q  <= 1'b0;
        end
    end

    assign pipe_start      = pipe_start_q;
    assign tx_end_ind      = end_q;
    assign rx_sigs_invalid = inval_q;
    assign usr_txen        = txen_q;
    assign tx_running      = !idle;
    assign rx_en           = cfg_rxen_opt && !tx_running;

    AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_end_ind |=> !tx_end_ind); // R5
    AST_LEVELS_NEED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sigs_invalid || usr_txen) |-> tx_running); // R6
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_start |=> !pipe_start); // R1
    AST_POST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_POST) |=> (phase == PH_POST || phase == PH_IDLE)); // R10
    AST_PIPE_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pipe_rst |=> (!tx_running && !rx_sigs_invalid && !usr_txen)); // R11
endmodule

// File: tb/sim_tx_seq_ctrl.sv
module sim_tx_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SW = 14;
    localparam int PW = 10;
    localparam int WATCHDOG = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_start_sel = 1'b0;
    logic [SW-1:0] cfg_start_dly = '0;
    logic [PW-1:0] cfg_end_dly = '0, cfg_inval_dly = '0, cfg_txen_dly = '0;
    logic cfg_rxen_opt = 1'b1, cfg_pipe_rst = 1'b0;
    logic sw_start = 1'b0, direct_start_i = 1'b0, mac_start_req = 1'b0, last_sample = 1'b0;
    logic pipe_start, tx_end_ind, rx_sigs_invalid, usr_txen, tx_running, rx_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_seq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_start_sel(cfg_start_sel),
        .cfg_start_dly(cfg_start_dly), .cfg_end_dly(cfg_end_dly),
        .cfg_inval_dly(cfg_inval_dly), .cfg_txen_dly(cfg_txen_dly),
        .cfg_rxen_opt(cfg_rxen_opt), .cfg_pipe_rst(cfg_pipe_rst),
        .sw_start(sw_start), .direct_start_i(direct_start_i),
        .mac_start_req(mac_start_req), .last_sample(last_sample),
        .pipe_start(pipe_start), .tx_end_ind(tx_end_ind),
        .rx_sigs_invalid(rx_sigs_invalid), .usr_txen(usr_txen),
        .tx_running(tx_running), .rx_en(rx_en)
    );

    function automatic int max3(int a, int b, int c);
        int m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic clear_trig();
        sw_start = 0; direct_start_i = 0; mac_start_req = 0; last_sample = 0;
    endtask

    // src 0: software, 1: direct input, 2: delayed MAC request
    task automatic run_tx(int src, int ds, int de, int di, int dt, int lat, bit noise);
        int dse = (src == 2) ? ds : 0;
        int mx = max3(de, di, dt);
        string stag = (dse == 0 && src == 2) ? "R3" : (src == 0) ? "R4" : (src == 1) ? "R1" : "R2";
        cfg_start_dly = SW'(ds); cfg_end_dly = PW'(de);
        cfg_inval_dly = PW'(di); cfg_txen_dly = PW'(dt);
        cfg_start_sel = (src == 1) ? 1'b0 : (src == 2) ? 1'b1 : 1'($urandom_range(0, 1));
        cfg_rxen_opt = 1'($urandom_range(0, 1));
        @(negedge clk);
        if (src == 0) sw_start = 1; else if (src == 1) direct_start_i = 1; else mac_start_req = 1;
        @(negedge clk);
        clear_trig();
        for (int n = 0; n <= 4*dse; n++) begin
            chk(stag, "pipe_start", pipe_start, (n == 4*dse));
            chk("R8", "tx_running", tx_running, 1);
            chk("R6", "rx_sigs_invalid", rx_sigs_invalid, (n == 4*dse));
            chk("R7", "usr_txen", usr_txen, (n == 4*dse));
            if (n < 4*dse) begin
                if (noise && n == 0) begin sw_start = 1; direct_start_i = 1; mac_start_req = 1; end // R10
                @(negedge clk);
                clear_trig();
            end
        end
        for (int k = 0; k < lat; k++) begin
            if (noise && k == 0) sw_start = 1; // R10: ignored while active
            @(negedge clk);
            clear_trig();
            chk("R10", "pipe_start", pipe_start, 0);
            chk("R6", "rx_sigs_invalid", rx_sigs_invalid, 1);
        end
        last_sample = 1;
        @(negedge clk);
        clear_trig();
        for (int m = 0; m <= 4*mx + 2; m++) begin
            chk((de == 0) ? "R3" : "R5", "tx_end_ind", tx_end_ind, (m == 4*de));
            chk((di == 0) ? "R3" : "R6", "rx_sigs_invalid", rx_sigs_invalid, (m < 4*di));
            chk((dt == 0) ? "R3" : "R7", "usr_txen", usr_txen, (m < 4*dt));
            chk("R8", "tx_running", tx_running, (m < 4*mx));
            chk("R9", "rx_en", rx_en, (cfg_rxen_opt && !(m < 4*mx)));
            chk("R10", "pipe_start", pipe_start, 0);
            if (noise && m == 1 && m < 4*mx) begin
                sw_start = 1; direct_start_i = 1; mac_start_req = 1; last_sample = 1;
            end
            @(negedge clk);
            clear_trig();
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        chk("R8", "reset tx_running", tx_running, 0);
        chk("R1", "reset pipe_start", pipe_start, 0);
        chk("R5", "reset tx_end_ind", tx_end_ind, 0);
        chk("R6", "reset rx_sigs_invalid", rx_sigs_invalid, 0);
        chk("R7", "reset usr_txen", usr_txen, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R9", "idle rx_en", rx_en, cfg_rxen_opt);

        // Directed corners
        run_tx(2, 0, 0, 0, 0, 0, 0);          // all-zero delays (R3)
        run_tx(0, 3, 2, 0, 5, 2, 1);          // software start, start delay unused (R4)
        run_tx(1, 7, 1, 3, 2, 1, 1);          // direct input start (R1)
        run_tx(2, 300, 1023, 2, 7, 3, 1);     // long start and end delays (R2, R5)

        // Wrong-source requests are ignored (R1, R2) and stray last_sample (R10)
        cfg_start_sel = 1; direct_start_i = 1; @(negedge clk); clear_trig();
        repeat (3) begin chk("R2", "direct ignored sel=1", tx_running, 0); @(negedge clk); end
        cfg_start_sel = 0; mac_start_req = 1; @(negedge clk); clear_trig();
        repeat (3) begin chk("R1", "mac ignored sel=0", tx_running, 0); @(negedge clk); end
        last_sample = 1; @(negedge clk); clear_trig();
        chk("R10", "idle last_sample tx_end_ind", tx_end_ind, 0);
        @(negedge clk);
        chk("R10", "idle last_sample tx_end_ind", tx_end_ind, 0);

        // Pipeline reset mid-extension (R11)
        cfg_end_dly = 5; cfg_inval_dly = 5; cfg_txen_dly = 5;
        sw_start = 1; @(negedge clk); clear_trig();
        last_sample = 1; @(negedge clk); clear_trig();
        repeat (3) @(negedge clk);
        cfg_pipe_rst = 1; @(negedge clk); cfg_pipe_rst = 0;
        for (int i = 0; i < 24; i++) begin
            chk("R11", "tx_running", tx_running, 0);
            chk("R11", "rx_sigs_invalid", rx_sigs_invalid, 0);
            chk("R11", "usr_txen", usr_txen, 0);
            chk("R11", "tx_end_ind", tx_end_ind, 0);
            @(negedge clk);
        end
        run_tx(2, 2, 1, 1, 1, 0, 0);          // normal after pipeline reset (R11)

        // Constrained random transactions
        for (int t = 0; t < 60; t++) begin
            int gap = $urandom_range(0, 3);
            repeat (gap) @(negedge clk);
            run_tx($urandom_range(0, 2), $urandom_range(0, 4), $urandom_range(0, 6),
                   $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 4),
                   1'($urandom_range(0, 1)));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule